// File: doc/BRIEF.md
# Clock Ratio Speed Detector

This block sits behind the serial audio input of a converter and works out how the oversampling path must be clocked. It counts fast master-clock cycles across each period of the frame clock, which runs at the sample rate, and turns that count into one of three speed modes: normal, double or quad. Alongside the mode it reports which of the seven supported master-to-frame ratios it measured, and a flag that says the reading is trustworthy.

It also supervises the clocks. If the frame clock goes quiet for longer than 2048 master-clock cycles, or the master clock stops, it raises an internal reset request. It drops that request only once both clocks are running again. A low power-down input holds everything in reset. A mode-select input chooses between auto mode, where the ratio picks the speed, and manual mode, where the speed is always normal.

The master clock is watched from a free-running reference clock. The frame clock is brought into the master-clock domain through a two-flop synchronizer.

Top module: `clock_ratio_detector`

## Requirements
- R1: In auto mode, measured ratios of 512, 768 and 1152 report speed code 0 (normal) with ratio codes 4, 5 and 6.
- R2: In auto mode, measured ratios of 256 and 384 report speed code 1 (double) with ratio codes 2 and 3.
- R3: In auto mode, measured ratios of 128 and 192 report speed code 2 (quad) with ratio codes 0 and 1.
- R4: In manual mode (autoMode low), the speed code is always 0 (normal) whatever the ratio. The ratio code still follows the table above, or reads 7 for a ratio not in it, and the valid flag still rises.
- R5: The valid flag rises only when two consecutive full frame periods measure the same ratio. After link start, valid is low after the second rising frame edge and high after the third. A change in period clears valid until two new periods agree.
- R6: In auto mode, a stable ratio that is in no table entry clears valid, sets ratio code 7 and keeps the previous speed code.
- R7: When no rising frame edge arrives for more than 2048 master-clock cycles, the reset request rises and valid falls. When the frame clock runs again, both recover.
- R8: When the master clock stops, the reset request rises within the reference-clock timeout. It clears after the master clock returns.
- R9: While pwrDnN is low, resetReq is 1, ratioValid is 0, speed code is 0 and ratio code is 7.
- R10: After pwrDnN rises, resetReq stays high until the master clock and at least one full frame period have both been seen.
- R11: A frame period of exactly 2048 master cycles is not a stopped clock: resetReq stays low, and in auto mode the reading is unknown (code 7, valid low). A period of 2052 cycles is treated as stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock for master-clock supervision |
| mclk | input | 1 | Master clock being measured |
| frameClk | input | 1 | Frame (sample-rate) clock, asynchronous to mclk |
| pwrDnN | input | 1 | Active-low power-down, asynchronous reset of the block |
| autoMode | input | 1 | 1 selects ratio-driven speed, 0 forces normal speed |
| speedMode | output | 2 | 0 normal, 1 double, 2 quad |
| ratioCode | output | 3 | 0..6 for ratios 128,192,256,384,512,768,1152; 7 unknown |
| ratioValid | output | 1 | Ratio and speed confirmed by two agreeing periods |
| resetReq | output | 1 | Internal reset request, high while clocks are absent |

## Verification
The bench targets the edge cases of the measurement window. A period of exactly 2048 cycles must not count as a stopped clock, while 2052 must; a design that used the wrong comparison would either reset on a legal slow clock or keep running on a dead one. It checks that valid waits for the third frame edge: a design that trusted the first partial period would raise valid one frame early, and would report whatever ratio the partial count happened to give. It also stops each clock in turn and checks that the reset request follows and then clears. An unknown ratio is made to follow a quad reading, so that a design which reset the mode instead of holding it shows up.

// File: rtl/clkratio_pkg.sv
`timescale 1ns/1ps
package clkratio_pkg;

  typedef enum logic [1:0] {
    SPEED_NORMAL = 2'd0,
    SPEED_DOUBLE = 2'd1,
    SPEED_QUAD   = 2'd2
  } speed_e;

  localparam logic [2:0] CODE_UNKNOWN = 3'd7;

  typedef struct packed {
    logic       known;
    speed_e     speed;
    logic [2:0] code;
  } ratioInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armCnt;
    logic takeSample;
    logic dropLink;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic frameEdge;
    logic overLimit;
  } dpStatus_t;

  function automatic ratioInfo_t classifyRatio(input int unsigned n);
    ratioInfo_t r;
    r.known = 1'b1;
    r.speed = SPEED_NORMAL;
    r.code  = CODE_UNKNOWN;
    case (n)
      128:     begin r.speed = SPEED_QUAD;   r.code = 3'd0; end
      192:     begin r.speed = SPEED_QUAD;   r.code = 3'd1; end
      256:     begin r.speed = SPEED_DOUBLE; r.code = 3'd2; end
      384:     begin r.speed = SPEED_DOUBLE; r.code = 3'd3; end
      512:     begin r.speed = SPEED_NORMAL; r.code = 3'd4; end
      768:     begin r.speed = SPEED_NORMAL; r.code = 3'd5; end
      1152:    begin r.speed = SPEED_NORMAL; r.code = 3'd6; end
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/crd_datapath.sv
`timescale 1ns/1ps
module crd_datapath
  import clkratio_pkg::*;
#(
  parameter int STOP_RATIO = 2048,
  parameter int HB_W       = 5
) (
  input  logic        mclk,
  input  logic        pwrDnN,
  input  logic        frameClk,
  input  logic        autoMode,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        hbBit,
  output speed_e      speedMode,
  output logic [2:0]  ratioCode,
  output logic        ratioValid
);

  localparam int CNT_W = $clog2(STOP_RATIO + 2);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(STOP_RATIO);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(STOP_RATIO + 1);

  logic [1:0]       frameSync;
  logic             frameDly;
  logic [1:0]       autoSync;
  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] prevPeriod;
  logic             havePrev;
  logic [HB_W-1:0]  hbCnt;
  logic             periodsAgree;
  ratioInfo_t       info;

  // frame clock synchronizer and rising-edge detector
  always_ff @(posedge mclk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      frameSync <= '0;
      frameDly  <= 1'b0;
      autoSync  <= '0;
    end else begin
      frameSync <= {frameSync[0], frameClk};
      frameDly  <= frameSync[1];
      autoSync  <= {autoSync[0], autoMode};
    end
  end

  assign status.frameEdge = frameSync[1] & ~frameDly;
  assign status.overLimit = (periodCnt > CNT_LIMIT);

  // period counter, saturating one past the stop limit
  always_ff @(posedge mclk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      periodCnt <= '0;
    end else if (strobe.armCnt || strobe.takeSample) begin
      periodCnt <= CNT_W'(1);
    end else if (periodCnt < CNT_SAT) begin
      periodCnt <= periodCnt + CNT_W'(1);
    end
  end

  // free-running heartbeat watched from the reference domain
  always_ff @(posedge mclk or negedge pwrDnN) begin
    if (!pwrDnN) hbCnt <= '0;
    else         hbCnt <= hbCnt + HB_W'(1);
  end
  assign hbBit = hbCnt[HB_W-1];

  assign info         = classifyRatio(32'(periodCnt));
  assign periodsAgree = havePrev && (periodCnt == prevPeriod);

  // sample history and result registers
  always_ff @(posedge mclk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      prevPeriod <= '0;
      havePrev   <= 1'b0;
      speedMode  <= SPEED_NORMAL;
      ratioCode  <= CODE_UNKNOWN;
      ratioValid <= 1'b0;
    end else if (strobe.dropLink || strobe.armCnt) begin
      havePrev   <= 1'b0;
      ratioValid <= 1'b0;
    end else if (strobe.takeSample) begin
      prevPeriod <= periodCnt;
      havePrev   <= 1'b1;
      if (!periodsAgree) begin
        ratioValid <= 1'b0;
      end else if (!autoSync[1]) begin
        speedMode  <= SPEED_NORMAL;
        ratioCode  <= info.code;
        ratioValid <= 1'b1;
      end else if (info.known) begin
        speedMode  <= info.speed;
        ratioCode  <= info.code;
        ratioValid <= 1'b1;
      end else begin
        ratioCode  <= CODE_UNKNOWN;
        ratioValid <= 1'b0;
      end
    end
  end

  a_r5_valid_after_sample: assert property (@(posedge mclk) disable iff (!pwrDnN)
    $rose(ratioValid) |-> $past(strobe.takeSample));

  a_r6_auto_valid_known: assert property (@(posedge mclk) disable iff (!pwrDnN)
    ($rose(ratioValid) && $past(autoSync[1])) |-> (ratioCode != CODE_UNKNOWN));

  a_r4_manual_normal: assert property (@(posedge mclk) disable iff (!pwrDnN)
    ($rose(ratioValid) && !$past(autoSync[1])) |-> (speedMode == SPEED_NORMAL));

  a_r7_drop_clears_valid: assert property (@(posedge mclk) disable iff (!pwrDnN)
    strobe.dropLink |=> !ratioValid);

endmodule

// File: rtl/crd_control.sv
`timescale 1ns/1ps
module crd_control
  import clkratio_pkg::*;
(
  input  logic        mclk,
  input  logic        pwrDnN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        linkUp
);

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ARM   = 2'd1,
    ST_TRACK = 2'd2
  } linkState_e;

  linkState_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_HUNT: begin
        if (status.frameEdge) begin
          strobe.armCnt = 1'b1;
          nextState     = ST_ARM;
        end
      end
      ST_ARM, ST_TRACK: begin
        if (status.overLimit) begin
          strobe.dropLink = 1'b1;
          nextState       = ST_HUNT;
        end else if (status.frameEdge) begin
          strobe.takeSample = 1'b1;
          nextState         = ST_TRACK;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge mclk or negedge pwrDnN) begin
    if (!pwrDnN) state <= ST_HUNT;
    else         state <= nextState;
  end

  assign linkUp = (state == ST_TRACK);

  a_r7_over_to_hunt: assert property (@(posedge mclk) disable iff (!pwrDnN)
    ((state != ST_HUNT) && status.overLimit) |=> (state == ST_HUNT));

  a_r10_track_needs_period: assert property (@(posedge mclk) disable iff (!pwrDnN)
    (state == ST_TRACK) |-> ($past(state) != ST_HUNT));

endmodule

// File: rtl/crd_mclk_watchdog.sv
`timescale 1ns/1ps
module crd_mclk_watchdog #(
  parameter int STOP_TIMEOUT = 32
) (
  input  logic refClk,
  input  logic pwrDnN,
  input  logic hbBit,
  input  logic linkUp,
  output logic resetReq
);

  localparam int TO_W = $clog2(STOP_TIMEOUT + 1);

  logic [2:0]      hbSync;
  logic [1:0]      linkSync;
  logic [TO_W-1:0] idleCnt;
  logic            mclkAlive;
  logic            hbChange;

  assign hbChange = hbSync[2] ^ hbSync[1];

  always_ff @(posedge refClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      hbSync    <= '0;
      linkSync  <= '0;
      idleCnt   <= '0;
      mclkAlive <= 1'b0;
      resetReq  <= 1'b1;
    end else begin
      hbSync   <= {hbSync[1:0], hbBit};
      linkSync <= {linkSync[0], linkUp};
      if (hbChange) begin
        idleCnt   <= '0;
        mclkAlive <= 1'b1;
      end else if (idleCnt >= TO_W'(STOP_TIMEOUT)) begin
        mclkAlive <= 1'b0;
      end else begin
        idleCnt <= idleCnt + TO_W'(1);
      end
      resetReq <= !(mclkAlive && linkSync[1]);
    end
  end

  a_r8_stop_raises_reset: assert property (@(posedge refClk) disable iff (!pwrDnN)
    $fell(mclkAlive) |=> resetReq);

  a_r10_release_needs_alive: assert property (@(posedge refClk) disable iff (!pwrDnN)
    $fell(resetReq) |-> $past(mclkAlive));

endmodule

// File: rtl/clock_ratio_detector.sv
`timescale 1ns/1ps
module clock_ratio_detector
  import clkratio_pkg::*;
#(
  parameter int STOP_RATIO   = 2048,
  parameter int HB_W         = 5,
  parameter int STOP_TIMEOUT = 32
) (
  input  logic       refClk,
  input  logic       mclk,
  input  logic       frameClk,
  input  logic       pwrDnN,
  input  logic       autoMode,
  output logic [1:0] speedMode,
  output logic [2:0] ratioCode,
  output logic       ratioValid,
  output logic       resetReq
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        hbBit;
  logic        linkUp;
  speed_e      speedQ;

  crd_datapath #(
    .STOP_RATIO (STOP_RATIO),
    .HB_W       (HB_W)
  ) u_dp (
    .mclk       (mclk),
    .pwrDnN     (pwrDnN),
    .frameClk   (frameClk),
    .autoMode   (autoMode),
    .strobe     (strobe),
    .status     (status),
    .hbBit      (hbBit),
    .speedMode  (speedQ),
    .ratioCode  (ratioCode),
    .ratioValid (ratioValid)
  );

  crd_control u_ctrl (
    .mclk   (mclk),
    .pwrDnN (pwrDnN),
    .status (status),
    .strobe (strobe),
    .linkUp (linkUp)
  );

  crd_mclk_watchdog #(
    .STOP_TIMEOUT (STOP_TIMEOUT)
  ) u_wd (
    .refClk   (refClk),
    .pwrDnN   (pwrDnN),
    .hbBit    (hbBit),
    .linkUp   (linkUp),
    .resetReq (resetReq)
  );

  assign speedMode = speedQ;

endmodule

// File: tb/clock_ratio_detector_tb.sv
`timescale 1ns/1ps
module clock_ratio_detector_tb;

  logic refClk = 1'b0;
  logic mclk = 1'b0;
  logic frameClk = 1'b0;
  logic pwrDnN = 1'b0;
  logic autoMode = 1'b1;
  logic mclkRun = 1'b1;
  logic frameRun = 1'b0;
  int   frameRatio = 512;
  int   fcnt = 0;
  logic [1:0] speedMode;
  logic [2:0] ratioCode;
  logic       ratioValid;
  logic       resetReq;

  int checkCount = 0;
  int failCount = 0;

  clock_ratio_detector u_dut (
    .refClk     (refClk),
    .mclk       (mclk),
    .frameClk   (frameClk),
    .pwrDnN     (pwrDnN),
    .autoMode   (autoMode),
    .speedMode  (speedMode),
    .ratioCode  (ratioCode),
    .ratioValid (ratioValid),
    .resetReq   (resetReq)
  );

  always #5 refClk = ~refClk;

  initial begin
    #1;
    forever begin
      if (mclkRun) mclk = ~mclk;
      #2;
    end
  end

  always @(negedge mclk) begin
    if (frameRun) begin
      frameClk <= (fcnt < frameRatio / 2);
      fcnt     <= (fcnt >= frameRatio - 1) ? 0 : fcnt + 1;
    end
  end

  // vector: {ratio[11:0], auto, mode[1:0], code[2:0], valid}
  localparam int NVEC = 11;
  localparam logic [18:0] VEC [NVEC] = '{
    {12'd512,  1'b1, 2'd0, 3'd4, 1'b1},
    {12'd768,  1'b1, 2'd0, 3'd5, 1'b1},
    {12'd1152, 1'b1, 2'd0, 3'd6, 1'b1},
    {12'd256,  1'b1, 2'd1, 3'd2, 1'b1},
    {12'd384,  1'b1, 2'd1, 3'd3, 1'b1},
    {12'd128,  1'b1, 2'd2, 3'd0, 1'b1},
    {12'd192,  1'b1, 2'd2, 3'd1, 1'b1},
    {12'd300,  1'b1, 2'd2, 3'd7, 1'b0},
    {12'd256,  1'b0, 2'd0, 3'd2, 1'b1},
    {12'd128,  1'b0, 2'd0, 3'd0, 1'b1},
    {12'd300,  1'b0, 2'd0, 3'd7, 1'b1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle(input int frames);
    repeat (frames) @(posedge frameClk);
    repeat (10) @(negedge refClk);
  endtask

  task automatic checkAll(input string req, input int expMode, input int expCode,
                          input int expValid, input int expReset);
    check(req, "speedMode", int'(speedMode), expMode);
    check(req, "ratioCode", int'(ratioCode), expCode);
    check(req, "ratioValid", int'(ratioValid), expValid);
    check(req, "resetReq", int'(resetReq), expReset);
  endtask

  initial begin
    #1_500_000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // R9: held in power-down
    repeat (20) @(negedge refClk);
    checkAll("R9", 0, 7, 0, 1);

    // R10: released, master clock running, frame clock idle
    pwrDnN = 1'b1;
    repeat (1200) @(negedge refClk);
    check("R10", "resetReq frame idle", int'(resetReq), 1);

    // R5: valid waits for two agreeing full periods
    frameRun = 1'b1;
    @(posedge frameClk);
    @(posedge frameClk);
    repeat (10) @(negedge refClk);
    check("R5", "valid after 2nd edge", int'(ratioValid), 0);
    @(posedge frameClk);
    repeat (10) @(negedge refClk);
    check("R5", "valid after 3rd edge", int'(ratioValid), 1);
    check("R10", "resetReq after link up", int'(resetReq), 0);

    // R1, R2, R3, R4, R6: table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      string tag;
      v = VEC[i];
      frameRatio = int'(v[18:7]);
      autoMode   = v[6];
      if (!v[6])           tag = "R4";
      else if (!v[0])      tag = "R6";
      else if (v[5:4] == 0) tag = "R1";
      else if (v[5:4] == 1) tag = "R2";
      else                 tag = "R3";
      settle(5);
      checkAll(tag, int'(v[5:4]), int'(v[3:1]), int'(v[0]), 0);
    end

    // R5: period change clears valid until two new periods agree
    autoMode = 1'b1;
    frameRatio = 512;
    settle(5);
    @(posedge frameClk);
    frameRatio = 768;
    @(posedge frameClk);
    repeat (10) @(negedge refClk);
    check("R5", "valid after change", int'(ratioValid), 0);
    @(posedge frameClk);
    repeat (10) @(negedge refClk);
    check("R5", "valid after agree", int'(ratioValid), 1);
    check("R5", "code after agree", int'(ratioCode), 5);

    // R11: 2048 is a legal (unknown) period, 2052 is stopped
    frameRatio = 2048;
    settle(4);
    check("R11", "resetReq at 2048", int'(resetReq), 0);
    check("R11", "code at 2048", int'(ratioCode), 7);
    check("R11", "valid at 2048", int'(ratioValid), 0);
    frameRatio = 2052;
    settle(4);
    check("R11", "resetReq at 2052", int'(resetReq), 1);
    check("R11", "valid at 2052", int'(ratioValid), 0);

    // R7: frame clock stops, then returns
    frameRatio = 512;
    settle(5);
    check("R7", "resetReq before stop", int'(resetReq), 0);
    frameRun = 1'b0;
    repeat (1000) @(negedge refClk);
    check("R7", "resetReq frame stopped", int'(resetReq), 1);
    check("R7", "valid frame stopped", int'(ratioValid), 0);
    frameRun = 1'b1;
    settle(5);
    check("R7", "resetReq frame back", int'(resetReq), 0);
    check("R7", "valid frame back", int'(ratioValid), 1);

    // R8: master clock stops, then returns
    mclkRun = 1'b0;
    repeat (100) @(negedge refClk);
    check("R8", "resetReq mclk stopped", int'(resetReq), 1);
    mclkRun = 1'b1;
    settle(5);
    check("R8", "resetReq mclk back", int'(resetReq), 0);
    check("R8", "valid mclk back", int'(ratioValid), 1);

    // R9: power-down in mid-run takes effect at once
    @(negedge refClk);
    pwrDnN = 1'b0;
    #1;
    checkAll("R9", 0, 7, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule